// File: doc/BRIEF.md
# Two-Bank Flash Bus Front End

This block presents the asynchronous pin-level bus of a two-bank parallel NOR-style flash to a host, and maps its read cycles onto an internal word-wide storage array. It decodes the active-low chip enable, output enable and write enable pins. It also decodes a byte/word width select pin. From these it drives a 16-bit data bus made of separate output-value and output-enable vectors, so a pad ring or a test harness can build the tristate buffers.

The width select pin sets the data width. With the pin high, a read drives the whole addressed word. With the pin low, only the low eight data lines are driven. The top data line then becomes an input that acts as an extra address bit below address bit 0, and it picks the low or high byte of the addressed word. When chip enable is high, the bus is in standby. When output enable is high, the outputs are disabled. In both cases every data line is released.

Each bank has its own small mode machine: array read, busy, or suspended. A separate command engine moves it with start, suspend, resume and done pulses. A read to a bank that is busy returns a fixed status word. A read to the other bank returns array data in the same cycle, so one bank can be read while the other is programming or erasing. While a bank is suspended, reads to any of its sectors except the one under erase return array data. Word-mode write cycles load the array directly, which lets a host or a bench fill it.

Top module: `dbf_front`

## Requirements
- R1: A read cycle in word mode (width select high) drives all 16 data lines with the addressed array word.
- R2: A read cycle in byte mode (width select low) drives data lines 0 to 7 and releases lines 8 to 15.
- R3: In byte mode, data line 15 is an input and acts as the least-significant address bit. A value of 0 returns bits 7:0 of the addressed word on lines 7:0, and a value of 1 returns bits 15:8.
- R4: After reset both banks are in array-read mode, and array data can be read with no command issued first.
- R5: A read cycle needs chip enable low, output enable low and write enable high. When write enable is low, no data line is driven.
- R6: When chip enable is high (standby), every data line is released, whatever the other pins are.
- R7: When chip enable is low and output enable is high (output disable), every data line is released.
- R8: The bank is chosen by the most-significant address bit. A read to a busy bank returns the status word 16'h0080 in word mode, or its selected byte in byte mode.
- R9: A read to a bank in array-read mode returns array data in the same cycle, even while the other bank is busy or suspended.
- R10: While a bank is suspended, a read to its latched sector (address bits 7:5) returns the status word, and a read to any other sector of that bank returns array data.
- R11: Bank mode transitions take effect on the clock edge. A start pulse takes a bank from read to busy and latches the sector input. Suspend takes it from busy to suspended, and resume takes it back to busy. Done returns it to read from any mode, and done wins over start in the same cycle.
- R12: A write cycle (chip enable low, write enable low, output enable high) in word mode stores the data input into the addressed word on the clock edge. The same cycle in byte mode leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the mode pulses and write cycles |
| rst_n | input | 1 | Asynchronous active-low reset of the bank modes |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| byte_n | input | 1 | Width select: 1 for word mode, 0 for byte mode |
| addr | input | AW (9) | Word address; the top bit selects the bank |
| dq_i | input | DW (16) | Data bus input value; bit 15 is the extra address bit in byte mode |
| dq_o | output | DW (16) | Data bus output value |
| dq_oe | output | DW (16) | Per-line output enable for the data bus |
| op_start | input | NUM_BANKS (2) | Per-bank pulse that starts a program or erase |
| op_suspend | input | NUM_BANKS (2) | Per-bank pulse that suspends the operation |
| op_resume | input | NUM_BANKS (2) | Per-bank pulse that resumes a suspended operation |
| op_done | input | NUM_BANKS (2) | Per-bank pulse that ends the operation |
| op_sector | input | SECT_W (3) | Sector latched by the bank that receives a start pulse |

## Verification
A bank mode that is wrong shows up at the first read to that bank after the faulty edge. The read returns the status word where array data was due, or array data where the status word was due. So the bench reads both banks and both kinds of sector after every mode pulse. A fault in pin decoding or byte steering is combinational, so it shows up on the output-enable vector or the low data byte in the same cycle as the stimulus. A write that lands when it should not stays hidden until that word is read back, so every ignored write is followed at once by a read of the same word.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   typedef enum logic [1:0] {
      BK_READ = 2'd0,
      BK_BUSY = 2'd1,
      BK_SUSP = 2'd2
   } bank_mode_e;

   typedef struct packed {
      logic wr;        // word-mode write strobe
      logic drive_lo;  // low byte lanes driven
      logic drive_hi;  // high byte lanes driven
   } bus_cyc_t;
endpackage

// File: rtl/dbf_bus_decode.sv
module dbf_bus_decode
   import dbf_pkg::*;
(
   input  logic     ce_n,
   input  logic     oe_n,
   input  logic     we_n,
   input  logic     byte_n,
   output bus_cyc_t cyc
);
   logic sel, rd;

   always_comb begin
      sel          = !ce_n;
      rd           = sel && !oe_n && we_n;
      cyc.drive_lo = rd;
      cyc.drive_hi = rd && byte_n;
      cyc.wr       = sel && !we_n && oe_n && byte_n;
   end
endmodule

// File: rtl/dbf_bank_ctl.sv
module dbf_bank_ctl
   import dbf_pkg::*;
#(
   parameter int SECT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              suspend,
   input  logic              resume,
   input  logic              done,
   input  logic [SECT_W-1:0] sector_i,
   output bank_mode_e        mode,
   output logic [SECT_W-1:0] sector_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= BK_READ;
         sector_q <= '0;
      end else if (done) begin
         mode <= BK_READ;
      end else begin
         unique case (mode)
            BK_READ: if (start) begin
               mode     <= BK_BUSY;
               sector_q <= sector_i;
            end
            BK_BUSY: if (suspend) mode <= BK_SUSP;
            BK_SUSP: if (resume)  mode <= BK_BUSY;
            default: mode <= BK_READ;
         endcase
      end
   end
endmodule

// File: rtl/dbf_word_array.sv
module dbf_word_array #(
   parameter int AW = 9,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          wen,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (wen) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];
endmodule

// File: rtl/dbf_byte_steer.sv
module dbf_byte_steer #(
   parameter int DW = 16
) (
   input  logic [DW-1:0] word,
   input  logic          byte_n,
   input  logic          lsb,
   input  logic          drive_lo,
   input  logic          drive_hi,
   output logic [DW-1:0] dq_o,
   output logic [DW-1:0] dq_oe
);
   localparam int HALF = DW / 2;

   logic [HALF-1:0] pick;

   assign pick = lsb ? word[DW-1:HALF] : word[HALF-1:0];
   assign dq_o = byte_n ? word : {{HALF{1'b0}}, pick};

   for (genvar i = 0; i < DW; i++) begin : g_lane
      if (i < HALF) begin : g_lo
         assign dq_oe[i] = drive_lo;
      end else begin : g_hi
         assign dq_oe[i] = drive_hi;
      end
   end
endmodule

// File: rtl/dbf_front.sv
module dbf_front
   import dbf_pkg::*;
#(
   parameter int          AW          = 9,
   parameter int          DW          = 16,
   parameter int          NUM_BANKS   = 2,
   parameter int          SECT_W      = 3,
   parameter logic [15:0] STATUS_WORD = 16'h0080
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ce_n,
   input  logic                 oe_n,
   input  logic                 we_n,
   input  logic                 byte_n,
   input  logic [AW-1:0]        addr,
   input  logic [DW-1:0]        dq_i,
   output logic [DW-1:0]        dq_o,
   output logic [DW-1:0]        dq_oe,
   input  logic [NUM_BANKS-1:0] op_start,
   input  logic [NUM_BANKS-1:0] op_suspend,
   input  logic [NUM_BANKS-1:0] op_resume,
   input  logic [NUM_BANKS-1:0] op_done,
   input  logic [SECT_W-1:0]    op_sector
);
   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int SEC_LO = AW - BANK_W - SECT_W;

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (DW < 16 || (DW % 2) != 0) begin : g_bad_dw
      $error("DW must be even and at least 16");
   end
   if (SEC_LO < 0) begin : g_bad_aw
      $error("AW too small for bank and sector fields");
   end

   bus_cyc_t                  cyc;
   bank_mode_e                mode_v   [NUM_BANKS];
   logic       [SECT_W-1:0]   sector_v [NUM_BANKS];
   logic       [BANK_W-1:0]   bank_sel;
   logic       [SECT_W-1:0]   sec_sel;
   logic       [DW-1:0]       arr_word, out_word;
   logic                      show_status;

   dbf_bus_decode u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .we_n   (we_n),
      .byte_n (byte_n),
      .cyc    (cyc)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      dbf_bank_ctl #(.SECT_W(SECT_W)) u_ctl (
         .clk      (clk),
         .rst_n    (rst_n),
         .start    (op_start[b]),
         .suspend  (op_suspend[b]),
         .resume   (op_resume[b]),
         .done     (op_done[b]),
         .sector_i (op_sector),
         .mode     (mode_v[b]),
         .sector_q (sector_v[b])
      );
   end

   dbf_word_array #(.AW(AW), .DW(DW)) u_arr (
      .clk   (clk),
      .wen   (cyc.wr),
      .waddr (addr),
      .wdata (dq_i),
      .raddr (addr),
      .rdata (arr_word)
   );

   assign bank_sel = addr[AW-1 -: BANK_W];
   assign sec_sel  = addr[SEC_LO +: SECT_W];

   always_comb begin
      unique case (mode_v[bank_sel])
         BK_BUSY: show_status = 1'b1;
         BK_SUSP: show_status = (sec_sel == sector_v[bank_sel]);
         default: show_status = 1'b0;
      endcase
      out_word = show_status ? DW'(STATUS_WORD) : arr_word;
   end

   dbf_byte_steer #(.DW(DW)) u_steer (
      .word     (out_word),
      .byte_n   (byte_n),
      .lsb      (dq_i[DW-1]),
      .drive_lo (cyc.drive_lo),
      .drive_hi (cyc.drive_hi),
      .dq_o     (dq_o),
      .dq_oe    (dq_oe)
   );
endmodule

// File: rtl/dbf_front_chk.sv
module dbf_front_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ce_n,
   input logic          oe_n,
   input logic          we_n,
   input logic          byte_n,
   input logic [DW-1:0] dq_oe
);
   localparam int HALF = DW / 2;

   // R6: standby releases the bus
   a_r6_standby_release: assert property (@(posedge clk) disable iff (!rst_n)
      ce_n |-> (dq_oe == '0));

   // R7: output disable releases the bus
   a_r7_out_disable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && oe_n) |-> (dq_oe == '0));

   // R5: a low write enable never lets the bus drive
   a_r5_we_blocks_read: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (dq_oe == '0));

   // R1: word read drives every lane
   a_r1_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n && byte_n) |-> (&dq_oe));

   // R2: byte read drives only the low lanes
   a_r2_byte_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && !oe_n && we_n && !byte_n) |->
         (dq_oe == {{HALF{1'b0}}, {HALF{1'b1}}}));
endmodule

bind dbf_front dbf_front_chk #(.DW(DW)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .ce_n   (ce_n),
   .oe_n   (oe_n),
   .we_n   (we_n),
   .byte_n (byte_n),
   .dq_oe  (dq_oe)
);

// File: tb/dbf_front_bench.sv
module dbf_front_bench;
   localparam int AW = 9;
   localparam int DEPTH = 512;
   localparam logic [15:0] STAT = 16'h0080;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1;
   logic [8:0]  addr = '0;
   logic [15:0] dq_i = '0;
   logic [15:0] dq_o, dq_oe;
   logic [1:0]  op_start = '0, op_suspend = '0, op_resume = '0, op_done = '0;
   logic [2:0]  op_sector = '0;

   int checks = 0;
   int fails  = 0;

   logic [15:0] ref_mem [DEPTH];
   int          ref_mode [2];   // 0 read, 1 busy, 2 suspended
   int          ref_sec  [2];

   always #10 clk = ~clk;   // 50 MHz

   dbf_front u_dbf_front (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .byte_n(byte_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
      .op_start(op_start), .op_suspend(op_suspend), .op_resume(op_resume),
      .op_done(op_done), .op_sector(op_sector)
   );

   function automatic logic [15:0] pattern(input int a);
      return 16'(a * 16'h0101) ^ 16'h5A3C;
   endfunction

   // one clock: check combinational outputs mid-cycle, then advance the model
   task automatic cyc(input string tag);
      logic [15:0] w, e_oe, e_d;
      int bk, sc;
      bk = int'(addr[8]);
      sc = int'(addr[7:5]);
      if (ref_mode[bk] == 1 || (ref_mode[bk] == 2 && sc == ref_sec[bk])) w = STAT;
      else w = ref_mem[addr];
      e_oe = '0; e_d = '0;
      if (!ce_n && !oe_n && we_n) begin
         if (byte_n) begin e_oe = 16'hFFFF; e_d = w; end
         else begin
            e_oe = 16'h00FF;
            e_d  = {8'h00, dq_i[15] ? w[15:8] : w[7:0]};
         end
      end
      @(negedge clk); #1;
      checks++;
      if (dq_oe !== e_oe || (dq_o & dq_oe) !== e_d) begin
         fails++;
         $display("FAIL %s: addr=%h oe=%h d=%h expected oe=%h d=%h",
                  tag, addr, dq_oe, dq_o & dq_oe, e_oe, e_d);
      end
      @(posedge clk);
      if (!ce_n && !we_n && oe_n && byte_n) ref_mem[addr] = dq_i;
      for (int b = 0; b < 2; b++) begin
         if (!rst_n || op_done[b]) ref_mode[b] = 0;
         else if (ref_mode[b] == 0 && op_start[b]) begin
            ref_mode[b] = 1; ref_sec[b] = int'(op_sector);
         end
         else if (ref_mode[b] == 1 && op_suspend[b]) ref_mode[b] = 2;
         else if (ref_mode[b] == 2 && op_resume[b]) ref_mode[b] = 1;
      end
      #1;
   endtask

   task automatic idle(input string tag);
      ce_n = 1; oe_n = 1; we_n = 1; byte_n = 1;
      cyc(tag);
      op_start = '0; op_suspend = '0; op_resume = '0; op_done = '0;
   endtask

   task automatic rd_word(input int a, input string tag);
      ce_n = 0; oe_n = 0; we_n = 1; byte_n = 1; addr = 9'(a); dq_i = '0;
      cyc(tag);
   endtask

   task automatic rd_byte(input int a, input logic lsb, input string tag);
      ce_n = 0; oe_n = 0; we_n = 1; byte_n = 0; addr = 9'(a);
      dq_i = {lsb, 15'h0};
      cyc(tag);
   endtask

   task automatic wr(input int a, input logic [15:0] d, input logic bn, input string tag);
      ce_n = 0; oe_n = 1; we_n = 0; byte_n = bn; addr = 9'(a); dq_i = d;
      cyc(tag);
   endtask

   initial begin
      #4_000_000;
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      ref_mode[0] = 0; ref_mode[1] = 0; ref_sec[0] = 0; ref_sec[1] = 0;
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 'x;
      #1;
      // R4/R6: reset state, standby, all lines released
      oe_n = 0;
      for (int i = 0; i < 3; i++) cyc("R6 standby during reset");
      rst_n = 1;
      oe_n = 1;
      // R12: preload, writes drive nothing (R5)
      for (int i = 0; i < DEPTH; i++) wr(i, pattern(i), 1'b1, "R12 R5 preload write");
      // R4/R1: reads with no command, both banks
      rd_word(0, "R4 read after reset");
      rd_word(300, "R4 read after reset bank1");
      for (int i = 1; i < DEPTH; i += 37) rd_word(i, "R1 word read");
      // R2/R3 byte reads
      for (int i = 5; i < DEPTH; i += 61) begin
         rd_byte(i, 1'b0, "R3 byte low");
         rd_byte(i, 1'b1, "R3 byte high");
         rd_byte(i, 1'b1, "R2 byte lanes");
      end
      // R7 output disable, R6 standby with read pins, R5 we low
      ce_n = 0; oe_n = 1; we_n = 1; byte_n = 1; addr = 9'd17; cyc("R7 output disable");
      ce_n = 1; oe_n = 0; cyc("R6 standby oe low");
      ce_n = 0; oe_n = 0; we_n = 0; cyc("R5 we low blocks read");
      // R12: byte-mode write ignored, word write lands
      wr(40, 16'hDEAD, 1'b0, "R12 byte write cycle");
      rd_word(40, "R12 byte write ignored");
      wr(41, 16'hBEEF, 1'b1, "R12 word write cycle");
      rd_word(41, "R12 word write stored");
      // R11/R8/R9: start bank1 on sector 3
      op_start = 2'b10; op_sector = 3'd3; idle("R11 start bank1");
      rd_word(256 + 3*32 + 4, "R8 busy bank status");
      rd_word(256 + 7*32, "R8 busy bank other sector");
      rd_byte(300, 1'b0, "R8 busy byte low");
      rd_byte(300, 1'b1, "R8 busy byte high");
      rd_word(10, "R9 idle bank while other busy");
      rd_byte(200, 1'b1, "R9 idle bank byte read");
      // R11/R10: suspend
      op_suspend = 2'b10; idle("R11 suspend bank1");
      rd_word(256 + 3*32 + 1, "R10 suspended erasing sector");
      rd_word(256 + 5*32 + 2, "R10 suspended other sector");
      rd_byte(256 + 0*32 + 9, 1'b1, "R10 suspended other sector byte");
      rd_word(100, "R9 bank0 while bank1 suspended");
      // R11 resume then done
      op_resume = 2'b10; idle("R11 resume bank1");
      rd_word(256 + 5*32 + 2, "R11 resumed busy again");
      op_done = 2'b10; idle("R11 done bank1");
      rd_word(256 + 3*32 + 4, "R11 back to read");
      // R11: done beats start
      op_start = 2'b01; op_done = 2'b01; op_sector = 3'd1; idle("R11 done over start");
      rd_word(32 + 3, "R11 done wins");
      // bank0 busy, bank1 readable
      op_start = 2'b01; op_sector = 3'd2; idle("R11 start bank0");
      rd_word(64 + 1, "R8 bank0 busy");
      rd_word(400, "R9 bank1 while bank0 busy");
      rd_word(0, "R8 bank0 other sector busy");
      // R4: reset returns banks to read
      rst_n = 0; idle("R4 reset asserted");
      rst_n = 1;
      rd_word(64 + 1, "R4 read after mid-run reset");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule